// File: doc/BRIEF.md
# FSK Cassette Byte Demodulator

This block turns the one-bit tape signal into bytes. It measures the time from one leading edge to the next leading edge. A trailing edge plays no part in the measurement, so a change in the duty cycle or a drift in the DC level does not alter the result. Each measured cycle is graded as a short "mark", a long "space", or noise. Two cycles of the same grade make one bit. The bits are framed into bytes, and a byte is passed on only after a run of sync bytes.

A free-running `tick` strobe sets the time unit. With the defaults and one tick every 0.1 ms, a mark lasts 6 ticks and a space lasts 12. The input must already be synchronised to `clk`. The receiver stays silent until it has seen enough consecutive 0xFF bytes. It then drops the remaining 0xFF preamble and releases the first other byte and every byte after it. A noise cycle or a long silence means the carrier is lost, and the receiver goes back to hunting for sync.

Top module: `cas_fsk_demod`

## Requirements
- R1: A cycle period is the number of ticks between two consecutive rising edges of `cas_in`. The first rising edge after reset, or after a carrier loss by timeout, only starts a measurement. The high/low split within a cycle has no effect.
- R2: A period from MIN_TICKS to SPLIT_TICKS is a mark (defaults 3 to 9). A period above SPLIT_TICKS up to MAX_TICKS is a space (defaults 10 to 20). Any other period is noise.
- R3: Two consecutive cycles of the same grade form one bit: two marks give 1 and two spaces give 0. A lone cycle followed by a cycle of the other grade is dropped, and the newer cycle starts a new pair.
- R4: A frame is one start bit of 0, then 8 data bits least-significant bit first, then 2 stop bits of 1. Bits of 1 while hunting for a start bit are ignored.
- R5: A 0 where a stop bit is expected discards the byte and raises `frame_err` for one clock. The receiver then hunts for a new start bit. Before sync, this also restarts the sync count. After sync, `synced` stays high.
- R6: `synced` rises after 6 consecutive complete bytes of 0xFF. Any other byte, or a framing error, before that point restarts the count.
- R7: While synced, 0xFF bytes that come before the first other byte are dropped. That first other byte and every later byte (0xFF included) appear on `byte_data` with `byte_vld` high for exactly one clock.
- R8: A noise cycle, or more than MAX_TICKS ticks without a rising edge, clears `synced`, the pending cycle and any partly built byte, without raising `frame_err`.
- R9: After reset, `byte_vld`, `synced` and `frame_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock timing strobe that sets the tick unit |
| cas_in | input | 1 | Synchronised tape signal |
| byte_data | output | 8 | Received byte, valid while `byte_vld` is high |
| byte_vld | output | 1 | One-clock strobe for a released byte |
| synced | output | 1 | Sync run seen, carrier still present |
| frame_err | output | 1 | One-clock pulse on a bad stop bit |

## Verification
The bench starts with an odd number of preamble marks, so the cycle pairing is misaligned until the first start bit. A design that never re-pairs would decode every later byte shifted by one cycle. It sends cycles with a lopsided duty. A design that timed from mixed edges would grade these as the wrong class. It also drives periods exactly at 3, 9, 10 and 20 ticks, where an off-by-one comparison turns a bit over or rejects it as noise.

On the sync side, the bench breaks a run of five 0xFF bytes with another byte. It also places a 0xFF after data has started. A design that did not restart the count would sync early. A design that kept filtering 0xFF would lose a data byte. Finally, the bench injects a bad stop bit, a short noise cycle and a long silence, and expects a single error pulse in the first case and loss of sync in the other two.

// File: rtl/cas_pkg.sv
package cas_pkg;

    localparam int unsigned CAS_BYTE_W = 8;

    typedef enum logic [1:0] {
        CYC_MARK  = 2'd0,
        CYC_SPACE = 2'd1,
        CYC_NOISE = 2'd2
    } cyc_class_e;

    typedef struct packed {
        logic       vld;
        cyc_class_e cls;
    } cyc_evt_t;

    typedef struct packed {
        logic vld;
        logic val;
        logic flush;
    } bit_evt_t;

    typedef struct packed {
        logic                  vld;
        logic [CAS_BYTE_W-1:0] data;
        logic                  ferr;
        logic                  lost;
    } byte_evt_t;

    typedef enum logic [1:0] {
        FR_HUNT = 2'd0,
        FR_DATA = 2'd1,
        FR_STOP = 2'd2
    } frame_st_e;

    function automatic cyc_class_e classify(input int unsigned per,
                                            input int unsigned lo,
                                            input int unsigned split,
                                            input int unsigned hi);
        if (per < lo || per > hi)
            return CYC_NOISE;
        else if (per > split)
            return CYC_SPACE;
        else
            return CYC_MARK;
    endfunction

endpackage

// File: rtl/cas_cycle_meas.sv
module cas_cycle_meas
    import cas_pkg::*;
#(
    parameter bit          LEAD_RISE = 1'b1,
    parameter int unsigned MIN_T     = 3,
    parameter int unsigned SPLIT_T   = 9,
    parameter int unsigned MAX_T     = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    output cyc_evt_t evt
);

    localparam int unsigned CW = $clog2(MAX_T + 2);
    localparam logic [CW-1:0] CAP = CW'(MAX_T + 1);

    logic          line_q;
    logic          edge_hit;
    logic          armed;
    logic [CW-1:0] cnt;

    generate
        if (LEAD_RISE) begin : g_rise
            assign edge_hit = line & ~line_q;
        end else begin : g_fall
            assign edge_hit = ~line & line_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= ~LEAD_RISE;
            armed   <= 1'b0;
            cnt     <= '0;
            evt.vld <= 1'b0;
            evt.cls <= CYC_MARK;
        end else begin
            line_q  <= line;
            evt.vld <= 1'b0;
            if (edge_hit) begin
                cnt   <= CW'(tick);
                armed <= 1'b1;
                if (armed) begin
                    evt.vld <= 1'b1;
                    evt.cls <= classify(32'(cnt), MIN_T, SPLIT_T, MAX_T);
                end
            end else if (tick && cnt != CAP) begin
                cnt <= cnt + 1'b1;
            end else if (armed && cnt == CAP) begin
                evt.vld <= 1'b1;
                evt.cls <= CYC_NOISE;
                armed   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cas_bit_pair.sv
module cas_bit_pair
    import cas_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cyc_evt_t cyc,
    output bit_evt_t bit_o
);

    logic       held;
    cyc_class_e held_cls;

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= 1'b0;
            held_cls <= CYC_MARK;
            bit_o    <= '0;
        end else begin
            bit_o.vld   <= 1'b0;
            bit_o.flush <= 1'b0;
            if (cyc.vld) begin
                if (cyc.cls == CYC_NOISE) begin
                    held        <= 1'b0;
                    bit_o.flush <= 1'b1;
                end else if (held && held_cls == cyc.cls) begin
                    held      <= 1'b0;
                    bit_o.vld <= 1'b1;
                    bit_o.val <= (cyc.cls == CYC_MARK);
                end else begin
                    held     <= 1'b1;
                    held_cls <= cyc.cls;
                end
            end
        end
    end

endmodule

// File: rtl/cas_framer.sv
module cas_framer
    import cas_pkg::*;
#(
    parameter int unsigned STOP_N = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  bit_evt_t  bit_i,
    output byte_evt_t out
);

    localparam int unsigned IW = $clog2(CAS_BYTE_W);
    localparam int unsigned SW = $clog2(STOP_N + 1);
    localparam logic [IW-1:0] LAST_IDX  = IW'(CAS_BYTE_W - 1);
    localparam logic [SW-1:0] LAST_STOP = SW'(STOP_N - 1);

    frame_st_e             st;
    logic [IW-1:0]         idx;
    logic [SW-1:0]         scnt;
    logic [CAS_BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= FR_HUNT;
            idx   <= '0;
            scnt  <= '0;
            shreg <= '0;
            out   <= '0;
        end else begin
            out.vld  <= 1'b0;
            out.ferr <= 1'b0;
            out.lost <= 1'b0;
            if (bit_i.flush) begin
                st       <= FR_HUNT;
                out.lost <= 1'b1;
            end else if (bit_i.vld) begin
                unique case (st)
                    FR_HUNT: begin
                        if (!bit_i.val) begin
                            st  <= FR_DATA;
                            idx <= '0;
                        end
                    end
                    FR_DATA: begin
                        shreg <= {bit_i.val, shreg[CAS_BYTE_W-1:1]};
                        if (idx == LAST_IDX) begin
                            st   <= FR_STOP;
                            scnt <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    FR_STOP: begin
                        if (!bit_i.val) begin
                            out.ferr <= 1'b1;
                            st       <= FR_HUNT;
                        end else if (scnt == LAST_STOP) begin
                            out.vld  <= 1'b1;
                            out.data <= shreg;
                            st       <= FR_HUNT;
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                    end
                    default: st <= FR_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/cas_sync_gate.sv
module cas_sync_gate
    import cas_pkg::*;
#(
    parameter int unsigned          RUN = 6,
    parameter logic [CAS_BYTE_W-1:0] PAT = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  byte_evt_t             in,
    output logic [CAS_BYTE_W-1:0] data_o,
    output logic                  vld_o,
    output logic                  synced_o,
    output logic                  ferr_o
);

    localparam int unsigned RW = $clog2(RUN + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN - 1);

    logic [RW-1:0] run;
    logic          passing;

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= '0;
            passing  <= 1'b0;
            synced_o <= 1'b0;
            vld_o    <= 1'b0;
            ferr_o   <= 1'b0;
            data_o   <= '0;
        end else begin
            vld_o  <= 1'b0;
            ferr_o <= in.ferr;
            if (in.lost) begin
                run      <= '0;
                passing  <= 1'b0;
                synced_o <= 1'b0;
            end else if (in.ferr) begin
                if (!synced_o)
                    run <= '0;
            end else if (in.vld) begin
                if (!synced_o) begin
                    if (in.data == PAT) begin
                        if (run == RUN_LAST) begin
                            synced_o <= 1'b1;
                            run      <= '0;
                        end else begin
                            run <= run + 1'b1;
                        end
                    end else begin
                        run <= '0;
                    end
                end else if (passing || in.data != PAT) begin
                    passing <= 1'b1;
                    vld_o   <= 1'b1;
                    data_o  <= in.data;
                end
            end
        end
    end

endmodule

// File: rtl/cas_fsk_demod.sv
module cas_fsk_demod
    import cas_pkg::*;
#(
    parameter bit                    LEAD_RISE   = 1'b1,
    parameter int unsigned           MIN_TICKS   = 3,
    parameter int unsigned           SPLIT_TICKS = 9,
    parameter int unsigned           MAX_TICKS   = 20,
    parameter int unsigned           STOP_BITS   = 2,
    parameter int unsigned           SYNC_RUN    = 6,
    parameter logic [CAS_BYTE_W-1:0] SYNC_BYTE   = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  cas_in,
    output logic [CAS_BYTE_W-1:0] byte_data,
    output logic                  byte_vld,
    output logic                  synced,
    output logic                  frame_err
);

    cyc_evt_t              cyc_w;
    bit_evt_t              bit_w;
    byte_evt_t             fr_w;
    logic                  fr_vld;
    logic [CAS_BYTE_W-1:0] fr_data;
    logic                  lost_w;

    assign fr_vld  = fr_w.vld;
    assign fr_data = fr_w.data;
    assign lost_w  = fr_w.lost;

    cas_cycle_meas #(
        .LEAD_RISE(LEAD_RISE),
        .MIN_T    (MIN_TICKS),
        .SPLIT_T  (SPLIT_TICKS),
        .MAX_T    (MAX_TICKS)
    ) meas_i (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .line(cas_in),
        .evt (cyc_w)
    );

    cas_bit_pair pair_i (
        .clk  (clk),
        .rst  (rst),
        .cyc  (cyc_w),
        .bit_o(bit_w)
    );

    cas_framer #(
        .STOP_N(STOP_BITS)
    ) framer_i (
        .clk  (clk),
        .rst  (rst),
        .bit_i(bit_w),
        .out  (fr_w)
    );

    cas_sync_gate #(
        .RUN(SYNC_RUN),
        .PAT(SYNC_BYTE)
    ) gate_i (
        .clk     (clk),
        .rst     (rst),
        .in      (fr_w),
        .data_o  (byte_data),
        .vld_o   (byte_vld),
        .synced_o(synced),
        .ferr_o  (frame_err)
    );

endmodule

// File: rtl/cas_fsk_demod_chk.sv
module cas_fsk_demod_chk #(
    parameter logic [7:0] PAT = 8'hFF
) (
    input logic       clk,
    input logic       rst,
    input logic       lost,
    input logic       fr_vld,
    input logic [7:0] fr_data,
    input logic       byte_vld,
    input logic [7:0] byte_data,
    input logic       synced,
    input logic       frame_err
);

    logic first_pend;

    always_ff @(posedge clk) begin
        if (rst)
            first_pend <= 1'b0;
        else if (!synced)
            first_pend <= 1'b1;
        else if (byte_vld)
            first_pend <= 1'b0;
    end

    // R7
    out_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> synced);

    // R7
    one_cycle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R7
    first_not_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && first_pend) |-> (byte_data != PAT));

    // R5
    err_excl_data_chk: assert property (@(posedge clk) disable iff (rst)
        !(byte_vld && frame_err));

    // R6
    sync_after_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(synced) |-> $past(fr_vld && fr_data == PAT));

    // R8
    loss_clears_sync_chk: assert property (@(posedge clk) disable iff (rst)
        lost |=> !synced);

endmodule

bind cas_fsk_demod cas_fsk_demod_chk #(.PAT(SYNC_BYTE)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .lost     (lost_w),
    .fr_vld   (fr_vld),
    .fr_data  (fr_data),
    .byte_vld (byte_vld),
    .byte_data(byte_data),
    .synced   (synced),
    .frame_err(frame_err)
);

// File: tb/cas_fsk_demod_tb_top.sv
`timescale 1ns/1ps
module cas_fsk_demod_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cas_in = 1'b0;
    logic [7:0] byte_data;
    logic       byte_vld;
    logic       synced;
    logic       frame_err;

    int total = 0;
    int bad = 0;
    int ferr_seen = 0;
    int ferr_exp = 0;
    int cyc_cnt = 0;
    logic [1:0] div = '0;

    int mk_hi = 3, mk_lo = 3, sp_hi = 6, sp_lo = 6;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    cas_fsk_demod dut_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cas_in   (cas_in),
        .byte_data(byte_data),
        .byte_vld (byte_vld),
        .synced   (synced),
        .frame_err(frame_err)
    );

    always @(posedge clk) begin
        if (rst) begin
            div  <= '0;
            tick <= 1'b0;
        end else begin
            div  <= div + 1'b1;
            tick <= (div == 2'd3);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected byte", int'(byte_data), -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(byte_data == e, "R4 R7 byte", int'(byte_data), int'(e));
                end
            end
            if (frame_err) ferr_seen++;
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 190000) begin
            chk(1'b0, "watchdog", cyc_cnt, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!tick);
        end
    endtask

    task automatic cyc(input int hi, input int lo);
        cas_in = 1'b1;
        wait_ticks(hi);
        cas_in = 1'b0;
        wait_ticks(lo);
    endtask

    task automatic send_bit(input bit b);
        for (int i = 0; i < 2; i++) begin
            if (b) cyc(mk_hi, mk_lo);
            else   cyc(sp_hi, sp_lo);
        end
    endtask

    task automatic gap();
        cyc(mk_hi, mk_lo);
        cyc(mk_hi, mk_lo);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit good_stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(1'b1);
        send_bit(good_stop);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit expect_out);
        if (expect_out) exp_q.push_back(d);
        send_frame(d, 1'b1);
        gap();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(byte_vld == 1'b0, "R9 byte_vld", int'(byte_vld), 0);
        chk(synced == 1'b0, "R9 synced", int'(synced), 0);
        chk(frame_err == 1'b0, "R9 frame_err", int'(frame_err), 0);
        @(negedge clk);
        rst = 1'b0;
        wait_ticks(1);

        // R3: odd count of preamble marks, then sync run
        for (int i = 0; i < 5; i++) cyc(mk_hi, mk_lo);
        for (int i = 0; i < 5; i++) send_byte(8'hFF, 1'b0);
        chk(synced == 1'b0, "R6 five sync bytes", int'(synced), 0);
        send_byte(8'hFF, 1'b0);
        chk(synced == 1'b1, "R6 six sync bytes", int'(synced), 1);
        // R7: extra preamble bytes are dropped
        send_byte(8'hFF, 1'b0);
        send_byte(8'hFF, 1'b0);

        // R4 / R7 data, a 0xFF after data started is kept
        send_byte(8'h3C, 1'b1);
        send_byte(8'hA5, 1'b1);
        send_byte(8'hFF, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h80, 1'b1);
        send_byte(8'h01, 1'b1);

        // R3: lone space cycle between frames is discarded
        cyc(sp_hi, sp_lo);
        gap();
        send_byte(8'h5A, 1'b1);

        // R1: lopsided duty, only rising-edge spacing matters
        mk_hi = 1; mk_lo = 5; sp_hi = 2; sp_lo = 10;
        send_byte(8'hC3, 1'b1);

        // R2 boundaries: mark 9, space 10
        mk_hi = 4; mk_lo = 5; sp_hi = 5; sp_lo = 5;
        send_byte(8'h96, 1'b1);
        // R2 boundaries: mark 3, space 20
        mk_hi = 1; mk_lo = 2; sp_hi = 10; sp_lo = 10;
        send_byte(8'h69, 1'b1);
        mk_hi = 3; mk_lo = 3; sp_hi = 6; sp_lo = 6;

        // R5 bad stop bit
        send_frame(8'h44, 1'b0);
        ferr_exp++;
        gap();
        chk(synced == 1'b1, "R5 sync kept after frame error", int'(synced), 1);
        send_byte(8'h21, 1'b1);

        // R8 noise cycle drops sync
        cyc(1, 1);
        gap();
        chk(synced == 1'b0, "R8 noise clears sync", int'(synced), 0);
        send_byte(8'h55, 1'b0);

        // R6 broken run restarts count
        for (int i = 0; i < 5; i++) send_byte(8'hFF, 1'b0);
        send_byte(8'h12, 1'b0);
        for (int i = 0; i < 5; i++) send_byte(8'hFF, 1'b0);
        chk(synced == 1'b0, "R6 run restarted", int'(synced), 0);
        send_byte(8'hFF, 1'b0);
        chk(synced == 1'b1, "R6 resync", int'(synced), 1);
        send_byte(8'h77, 1'b1);

        // R8 silence timeout drops sync
        cas_in = 1'b0;
        wait_ticks(30);
        chk(synced == 1'b0, "R8 timeout clears sync", int'(synced), 0);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);
        chk(ferr_seen == ferr_exp, "R5 frame_err pulses", ferr_seen, ferr_exp);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule